// File: doc/BRIEF.md
# Four-way instruction address translation buffer

The block translates instruction fetch virtual addresses to physical addresses through four fully associative entries. Each lookup compares the fetch address against every entry under its own page mask. The comparison also takes the current address-space identifier into account, unless the entry is marked shared. A single match gives a translation, which becomes a protection fault when a user-mode fetch hits an entry without user permission. Two or more matches report a multi-hit fault.

When nothing matches, the block issues a refill request to a larger unified translation buffer and waits for its answer. A successful answer is written into the least recently used slot, and the result is reported from the new entry. A miss or multi-hit answer is passed through as a fault, and no state changes. Recency is held in six bits, one bit per pair of slots. Software reads and writes the address and data halves of each slot through a small register port.

Top module: `fetch_tlb`

## Requirements
- R1: After reset the lookup port is ready, no result or refill request is pending, every slot reads back with its valid bit (bit 8) clear, and the recency state is 0, so the first four refills from reset fill slots 3, 2, 1, 0 in that order.
- R2: A slot matches a fetch when its valid flag (flag bit 8) is set, either its shared flag (flag bit 1) is set or its stored identifier equals `asid_i`, and the stored page number equals the fetch address under the slot's page mask.
- R3: Flag bits {7,4} select the page mask: 00 gives 1 KB (0xFFFFFC00), 01 gives 4 KB (0xFFFFF000), 10 gives 64 KB (0xFFFF0000), 11 gives 1 MB (0xFFF00000).
- R4: A single match raises `res_valid_o` in the cycle after the lookup is accepted. The result code is 0 (ok) and `res_paddr_o` = (ppn AND mask) OR (vaddr AND NOT mask).
- R5: Two or more matches give result code 2 (multi-hit) in the same cycle position, and the recency state is left unchanged.
- R6: The victim is slot 0 if (state AND 0x38) = 0x38, else slot 1 if (state AND 0x26) = 0x06, else slot 2 if (state AND 0x15) = 0x01, else slot 3. Using slot 0 sets state = state AND 0x07. Slot 1 sets (state AND 0x19) OR 0x20. Slot 2 sets (state AND 0x3E) OR 0x14. Slot 3 sets state OR 0x0B. Every hit, including a protection fault, counts as a use.
- R7: On no match, `ref_req_o` rises in the next cycle with `ref_vaddr_o` equal to the fetch address, and both hold until `ref_ready_i`. A response of kind 0 (hit) writes the victim slot with page number, identifier and PPN copied, and flags ANDed with 0x1DA. That slot is marked used, and the result, computed from the new slot, appears in the cycle after the response.
- R8: A response of kind 1 (miss) gives result code 1, and a response of kind 2 (multi-hit) gives result code 2. Neither changes any slot or the recency state.
- R9: A user-mode fetch (`user_mode_i`=1) that resolves to a slot whose user flag (flag bit 6) is clear gives result code 3 (protection).
- R10: Register access selects the slot with address bits 8:7. An address-half read, returned the cycle after the request, gives page number OR identifier OR (valid flag at bit 8). An address-half write sets the page number from bits 31:10, the identifier from bits 7:0 and the valid flag from bit 8, and leaves the other flags unchanged.
- R11: A data-half write stores the PPN from bits 28:10 and the flags as write data AND 0x1DA. A stored PPN at or above 0x1C000000 has bits 31:29 forced to 1. A data-half read returns (PPN AND 0x1FFFFC00) OR flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| asid_i | input | 8 | Current address-space identifier |
| user_mode_i | input | 1 | Fetch is issued from user mode |
| lookup_valid_i | input | 1 | Fetch lookup request |
| lookup_vaddr_i | input | 32 | Fetch virtual address |
| lookup_ready_o | output | 1 | A lookup can be accepted |
| res_valid_o | output | 1 | Result strobe |
| res_kind_o | output | 2 | 0 ok, 1 miss, 2 multi-hit, 3 protection |
| res_paddr_o | output | 32 | Physical address for an ok result |
| ref_req_o | output | 1 | Refill request to the unified buffer |
| ref_ready_i | input | 1 | Refill request taken |
| ref_vaddr_o | output | 32 | Address being refilled |
| ref_rsp_valid_i | input | 1 | Refill response strobe |
| ref_rsp_kind_i | input | 2 | 0 hit, 1 miss, 2 multi-hit |
| ref_rsp_vpn_i | input | 32 | Returned page number (bits 31:10) |
| ref_rsp_asid_i | input | 8 | Returned identifier |
| ref_rsp_ppn_i | input | 32 | Returned physical page number |
| ref_rsp_flags_i | input | 9 | Returned flags |
| mm_valid_i | input | 1 | Register access strobe |
| mm_write_i | input | 1 | Access is a write |
| mm_data_arr_i | input | 1 | 1 selects the data half, 0 the address half |
| mm_addr_i | input | 2 | Access address bits 8:7 (slot index) |
| mm_wdata_i | input | 32 | Write data |
| mm_rdata_o | output | 32 | Read data, valid the cycle after a read |

## Verification
A lookup that hits or multi-hits is due exactly one clock after the accepting edge. The bench drives on falling edges and samples at the falling edge that follows that rising edge. On a miss, the request is checked at the same point, then two cycles later to confirm it is held. After the ready edge it must have dropped, and the result is sampled one cycle after the response strobe. Register reads are checked one cycle after the read edge. The bench model keeps its own copy of the slots and the recency state, so every later victim choice and match depends on earlier updates having been right.

// File: rtl/fetch_tlb_pkg.sv
package fetch_tlb_pkg;
  localparam int NUM_WAYS = 4;
  localparam int WAY_W    = $clog2(NUM_WAYS);
  localparam int CNT_W    = $clog2(NUM_WAYS + 1);
  localparam int ASID_W   = 8;
  localparam int VA_W     = 32;
  localparam int FLAG_W   = 9;
  localparam int LRU_W    = 6;

  localparam int FB_SHARE = 1;
  localparam int FB_SZ_LO = 4;
  localparam int FB_USER  = 6;
  localparam int FB_SZ_HI = 7;
  localparam int FB_VALID = 8;

  localparam logic [FLAG_W-1:0] FLAG_KEEP   = 9'h1DA;
  localparam logic [VA_W-1:0]   VPN_MASK    = 32'hFFFF_FC00;
  localparam logic [VA_W-1:0]   PPN_MASK    = 32'h1FFF_FC00;
  localparam logic [VA_W-1:0]   PPN_HI_MIN  = 32'h1C00_0000;
  localparam logic [VA_W-1:0]   PPN_HI_SET  = 32'hE000_0000;

  localparam logic [1:0] RSP_HIT   = 2'd0;
  localparam logic [1:0] RSP_MULTI = 2'd2;

  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_MISS  = 2'd1,
    RES_MULTI = 2'd2,
    RES_PROT  = 2'd3
  } res_kind_e;

  typedef struct packed {
    logic [VA_W-1:0]   vpn;
    logic [ASID_W-1:0] asid;
    logic [VA_W-1:0]   ppn;
    logic [FLAG_W-1:0] flags;
  } tlb_entry_t;

  function automatic logic [VA_W-1:0] page_mask(input logic [FLAG_W-1:0] f);
    unique case ({f[FB_SZ_HI], f[FB_SZ_LO]})
      2'b00:   return 32'hFFFF_FC00;
      2'b01:   return 32'hFFFF_F000;
      2'b10:   return 32'hFFFF_0000;
      default: return 32'hFFF0_0000;
    endcase
  endfunction

  function automatic logic [VA_W-1:0] xlate(input tlb_entry_t e, input logic [VA_W-1:0] va);
    logic [VA_W-1:0] m;
    m = page_mask(e.flags);
    return (e.ppn & m) | (va & ~m);
  endfunction
endpackage

// File: rtl/fetch_tlb_lru.sv
module fetch_tlb_lru
  import fetch_tlb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             use_i,
  input  logic [WAY_W-1:0] use_idx_i,
  output logic [WAY_W-1:0] victim_o,
  output logic [LRU_W-1:0] state_o
);
  logic [LRU_W-1:0] lru_q, lru_d;

  // one bit per slot pair; the oldest slot is the one all its pairs point away from
  always_comb begin
    if ((lru_q & 6'h38) == 6'h38)      victim_o = 2'd0;
    else if ((lru_q & 6'h26) == 6'h06) victim_o = 2'd1;
    else if ((lru_q & 6'h15) == 6'h01) victim_o = 2'd2;
    else                               victim_o = 2'd3;
  end

  always_comb begin
    unique case (use_idx_i)
      2'd0:    lru_d = lru_q & 6'h07;
      2'd1:    lru_d = (lru_q & 6'h19) | 6'h20;
      2'd2:    lru_d = (lru_q & 6'h3E) | 6'h14;
      default: lru_d = lru_q | 6'h0B;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lru_q <= '0;
    else if (use_i) lru_q <= lru_d;
  end

  assign state_o = lru_q;

  AST_USED_NOT_VICTIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    use_i |=> victim_o != $past(use_idx_i)); // R6
endmodule

// File: rtl/fetch_tlb_array.sv
module fetch_tlb_array
  import fetch_tlb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [VA_W-1:0]   va_i,
  output logic [NUM_WAYS-1:0] hit_vec_o,
  output tlb_entry_t        ent_o [NUM_WAYS],
  input  logic              ld_en_i,
  input  logic [WAY_W-1:0]  ld_idx_i,
  input  tlb_entry_t        ld_entry_i,
  input  logic              mm_we_i,
  input  logic              mm_data_i,
  input  logic [WAY_W-1:0]  mm_idx_i,
  input  logic [VA_W-1:0]   mm_wdata_i
);
  logic [VA_W-1:0] ppn_raw, ppn_w;
  assign ppn_raw = mm_wdata_i & PPN_MASK;
  assign ppn_w   = (ppn_raw >= PPN_HI_MIN) ? (ppn_raw | PPN_HI_SET) : ppn_raw;

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
    tlb_entry_t e_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        e_q <= '0;
      end else if (ld_en_i && ld_idx_i == WAY_W'(g)) begin
        e_q <= ld_entry_i;
      end else if (mm_we_i && mm_idx_i == WAY_W'(g)) begin
        if (mm_data_i) begin
          e_q.ppn   <= ppn_w;
          e_q.flags <= mm_wdata_i[FLAG_W-1:0] & FLAG_KEEP;
        end else begin
          e_q.vpn             <= mm_wdata_i & VPN_MASK;
          e_q.asid            <= mm_wdata_i[ASID_W-1:0];
          e_q.flags[FB_VALID] <= mm_wdata_i[FB_VALID];
        end
      end
    end

    assign ent_o[g]     = e_q;
    assign hit_vec_o[g] = e_q.flags[FB_VALID] &&
                          (e_q.flags[FB_SHARE] || e_q.asid == asid_i) &&
                          (((e_q.vpn ^ va_i) & page_mask(e_q.flags)) == '0);
  end
endmodule

// File: rtl/fetch_tlb.sv
module fetch_tlb
  import fetch_tlb_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  asid_i,
  input  logic        user_mode_i,
  input  logic        lookup_valid_i,
  input  logic [31:0] lookup_vaddr_i,
  output logic        lookup_ready_o,
  output logic        res_valid_o,
  output logic [1:0]  res_kind_o,
  output logic [31:0] res_paddr_o,
  output logic        ref_req_o,
  input  logic        ref_ready_i,
  output logic [31:0] ref_vaddr_o,
  input  logic        ref_rsp_valid_i,
  input  logic [1:0]  ref_rsp_kind_i,
  input  logic [31:0] ref_rsp_vpn_i,
  input  logic [7:0]  ref_rsp_asid_i,
  input  logic [31:0] ref_rsp_ppn_i,
  input  logic [8:0]  ref_rsp_flags_i,
  input  logic        mm_valid_i,
  input  logic        mm_write_i,
  input  logic        mm_data_arr_i,
  input  logic [8:7]  mm_addr_i,
  input  logic [31:0] mm_wdata_i,
  output logic [31:0] mm_rdata_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} st_e;

  st_e              state_q;
  logic [VA_W-1:0]  va_q;
  logic             user_q;
  logic [NUM_WAYS-1:0] hit_vec;
  tlb_entry_t       ents [NUM_WAYS];
  logic [CNT_W-1:0] hit_cnt;
  logic [WAY_W-1:0] hit_idx, victim;
  logic [LRU_W-1:0] lru_state;
  logic             accept, rsp_take, rsp_hit, lru_use;
  tlb_entry_t       sel_ent, rsp_ent;
  res_kind_e        kind_d, kind_q;
  logic [VA_W-1:0]  paddr_d, paddr_q;
  logic             res_valid_q;
  logic [VA_W-1:0]  mm_rdata_q;

  assign accept   = (state_q == ST_IDLE) && lookup_valid_i;
  assign rsp_take = (state_q == ST_WAIT) && ref_rsp_valid_i;
  assign rsp_hit  = rsp_take && (ref_rsp_kind_i == RSP_HIT);

  fetch_tlb_array u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .asid_i     (asid_i),
    .va_i       (lookup_vaddr_i),
    .hit_vec_o  (hit_vec),
    .ent_o      (ents),
    .ld_en_i    (rsp_hit),
    .ld_idx_i   (victim),
    .ld_entry_i (rsp_ent),
    .mm_we_i    (mm_valid_i && mm_write_i),
    .mm_data_i  (mm_data_arr_i),
    .mm_idx_i   (mm_addr_i),
    .mm_wdata_i (mm_wdata_i)
  );

  assign lru_use = (accept && hit_cnt == CNT_W'(1)) || rsp_hit;

  fetch_tlb_lru u_lru (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .use_i     (lru_use),
    .use_idx_i (rsp_hit ? victim : hit_idx),
    .victim_o  (victim),
    .state_o   (lru_state)
  );

  always_comb begin
    hit_cnt = '0;
    hit_idx = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (hit_vec[i]) begin
        hit_cnt = hit_cnt + CNT_W'(1);
        hit_idx = WAY_W'(i);
      end
    end
  end

  assign sel_ent = ents[hit_idx];

  always_comb begin
    rsp_ent.vpn   = ref_rsp_vpn_i & VPN_MASK;
    rsp_ent.asid  = ref_rsp_asid_i;
    rsp_ent.ppn   = ref_rsp_ppn_i;
    rsp_ent.flags = ref_rsp_flags_i & FLAG_KEEP;
  end

  always_comb begin
    kind_d  = RES_MISS;
    paddr_d = '0;
    if (rsp_take) begin
      if (ref_rsp_kind_i == RSP_HIT) begin
        kind_d  = (user_q && !rsp_ent.flags[FB_USER]) ? RES_PROT : RES_OK;
        paddr_d = xlate(rsp_ent, va_q);
      end else if (ref_rsp_kind_i == RSP_MULTI) begin
        kind_d = RES_MULTI;
      end
    end else if (hit_cnt > CNT_W'(1)) begin
      kind_d = RES_MULTI;
    end else begin
      kind_d  = (user_mode_i && !sel_ent.flags[FB_USER]) ? RES_PROT : RES_OK;
      paddr_d = xlate(sel_ent, lookup_vaddr_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      user_q      <= 1'b0;
      res_valid_q <= 1'b0;
      kind_q      <= RES_OK;
      paddr_q     <= '0;
    end else begin
      res_valid_q <= (accept && hit_cnt != '0) || rsp_take;
      if ((accept && hit_cnt != '0) || rsp_take) begin
        kind_q  <= kind_d;
        paddr_q <= paddr_d;
      end
      if (accept) begin
        va_q   <= lookup_vaddr_i;
        user_q <= user_mode_i;
      end
      unique case (state_q)
        ST_IDLE: if (accept && hit_cnt == '0) state_q <= ST_REQ;
        ST_REQ:  if (ref_ready_i)             state_q <= ST_WAIT;
        ST_WAIT: if (ref_rsp_valid_i)         state_q <= ST_IDLE;
        default:                              state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mm_rdata_q <= '0;
    end else if (mm_valid_i && !mm_write_i) begin
      if (mm_data_arr_i)
        mm_rdata_q <= (ents[mm_addr_i].ppn & PPN_MASK) | VA_W'(ents[mm_addr_i].flags);
      else
        mm_rdata_q <= ents[mm_addr_i].vpn | VA_W'(ents[mm_addr_i].asid) |
                      (VA_W'(ents[mm_addr_i].flags[FB_VALID]) << FB_VALID);
    end
  end

  assign lookup_ready_o = (state_q == ST_IDLE);
  assign res_valid_o    = res_valid_q;
  assign res_kind_o     = kind_q;
  assign res_paddr_o    = paddr_q;
  assign ref_req_o      = (state_q == ST_REQ);
  assign ref_vaddr_o    = va_q;
  assign mm_rdata_o     = mm_rdata_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o && !ref_ready_i |=> ref_req_o && $stable(ref_vaddr_o)); // R7
  AST_MULTI_KEEPS_LRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_kind_o == RES_MULTI |-> lru_state == $past(lru_state)); // R5
  AST_OK_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_kind_o == RES_OK |-> res_paddr_o[9:0] == va_q[9:0]); // R4
  AST_MISS_FAULT_KEEPS_LRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_kind_o == RES_MISS |-> lru_state == $past(lru_state)); // R8
endmodule

// File: tb/fetch_tlb_test.sv
`timescale 1ns/1ps
module fetch_tlb_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  asid_i = '0;
  logic        user_mode_i = 1'b0;
  logic        lookup_valid_i = 1'b0;
  logic [31:0] lookup_vaddr_i = '0;
  logic        lookup_ready_o;
  logic        res_valid_o;
  logic [1:0]  res_kind_o;
  logic [31:0] res_paddr_o;
  logic        ref_req_o;
  logic        ref_ready_i = 1'b0;
  logic [31:0] ref_vaddr_o;
  logic        ref_rsp_valid_i = 1'b0;
  logic [1:0]  ref_rsp_kind_i = '0;
  logic [31:0] ref_rsp_vpn_i = '0;
  logic [7:0]  ref_rsp_asid_i = '0;
  logic [31:0] ref_rsp_ppn_i = '0;
  logic [8:0]  ref_rsp_flags_i = '0;
  logic        mm_valid_i = 1'b0;
  logic        mm_write_i = 1'b0;
  logic        mm_data_arr_i = 1'b0;
  logic [1:0]  mm_addr_i = '0;
  logic [31:0] mm_wdata_i = '0;
  logic [31:0] mm_rdata_o;

  always #2 clk = ~clk;

  fetch_tlb uut (
    .clk_i(clk), .rst_ni(rst_ni), .asid_i(asid_i), .user_mode_i(user_mode_i),
    .lookup_valid_i(lookup_valid_i), .lookup_vaddr_i(lookup_vaddr_i),
    .lookup_ready_o(lookup_ready_o), .res_valid_o(res_valid_o),
    .res_kind_o(res_kind_o), .res_paddr_o(res_paddr_o), .ref_req_o(ref_req_o),
    .ref_ready_i(ref_ready_i), .ref_vaddr_o(ref_vaddr_o),
    .ref_rsp_valid_i(ref_rsp_valid_i), .ref_rsp_kind_i(ref_rsp_kind_i),
    .ref_rsp_vpn_i(ref_rsp_vpn_i), .ref_rsp_asid_i(ref_rsp_asid_i),
    .ref_rsp_ppn_i(ref_rsp_ppn_i), .ref_rsp_flags_i(ref_rsp_flags_i),
    .mm_valid_i(mm_valid_i), .mm_write_i(mm_write_i), .mm_data_arr_i(mm_data_arr_i),
    .mm_addr_i(mm_addr_i), .mm_wdata_i(mm_wdata_i), .mm_rdata_o(mm_rdata_o)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] m_vpn [4];
  logic [31:0] m_ppn [4];
  logic [7:0]  m_asid [4];
  logic [8:0]  m_flags [4];
  logic [5:0]  m_lru;

  function automatic logic [31:0] b_mask(input logic [8:0] f);
    case ({f[7], f[4]})
      2'b00: return 32'hFFFF_FC00;
      2'b01: return 32'hFFFF_F000;
      2'b10: return 32'hFFFF_0000;
      default: return 32'hFFF0_0000;
    endcase
  endfunction

  function automatic int b_victim(input logic [5:0] s);
    if ((s & 6'h38) == 6'h38) return 0;
    if ((s & 6'h26) == 6'h06) return 1;
    if ((s & 6'h15) == 6'h01) return 2;
    return 3;
  endfunction

  function automatic logic [5:0] b_touch(input logic [5:0] s, input int n);
    case (n)
      0: return s & 6'h07;
      1: return (s & 6'h19) | 6'h20;
      2: return (s & 6'h3E) | 6'h14;
      default: return s | 6'h0B;
    endcase
  endfunction

  function automatic bit b_match(input int i, input logic [31:0] va, input logic [7:0] as);
    return m_flags[i][8] && (m_flags[i][1] || m_asid[i] == as) &&
           (((m_vpn[i] ^ va) & b_mask(m_flags[i])) == 32'h0);
  endfunction

  function automatic logic [31:0] b_pa(input int i, input logic [31:0] va);
    return (m_ppn[i] & b_mask(m_flags[i])) | (va & ~b_mask(m_flags[i]));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic mm_wr(input logic d, input int idx, input logic [31:0] w);
    logic [31:0] p;
    mm_valid_i = 1; mm_write_i = 1; mm_data_arr_i = d; mm_addr_i = 2'(idx); mm_wdata_i = w;
    @(posedge clk); @(negedge clk);
    mm_valid_i = 0; mm_write_i = 0;
    if (d) begin
      p = w & 32'h1FFF_FC00;
      if (p >= 32'h1C00_0000) p = p | 32'hE000_0000;
      m_ppn[idx] = p;
      m_flags[idx] = w[8:0] & 9'h1DA;
    end else begin
      m_vpn[idx] = w & 32'hFFFF_FC00;
      m_asid[idx] = w[7:0];
      m_flags[idx][8] = w[8];
    end
  endtask

  task automatic mm_rd(input logic d, input int idx, output logic [31:0] v);
    mm_valid_i = 1; mm_write_i = 0; mm_data_arr_i = d; mm_addr_i = 2'(idx);
    @(posedge clk); @(negedge clk);
    mm_valid_i = 0;
    v = mm_rdata_o;
  endtask

  task automatic mm_check(input int idx, input string req);
    logic [31:0] v;
    mm_rd(1'b0, idx, v);
    chk(v == (m_vpn[idx] | 32'(m_asid[idx]) | (32'(m_flags[idx][8]) << 8)), req, v,
        m_vpn[idx] | 32'(m_asid[idx]) | (32'(m_flags[idx][8]) << 8));
    mm_rd(1'b1, idx, v);
    chk(v == ((m_ppn[idx] & 32'h1FFF_FC00) | 32'(m_flags[idx])), req, v,
        (m_ppn[idx] & 32'h1FFF_FC00) | 32'(m_flags[idx]));
  endtask

  task automatic do_lookup(input logic [31:0] va, input logic usr, input logic [7:0] as,
                           input logic [1:0] rk, input logic [31:0] rppn,
                           input logic [8:0] rfl, input string req);
    int n = 0;
    int idx = 0;
    int v;
    logic [1:0] ek;
    logic [31:0] ep;
    for (int i = 0; i < 4; i++) if (b_match(i, va, as)) begin n++; idx = i; end
    chk(lookup_ready_o == 1'b1, req, 32'(lookup_ready_o), 32'd1);
    lookup_vaddr_i = va; user_mode_i = usr; asid_i = as; lookup_valid_i = 1;
    @(posedge clk); @(negedge clk);
    lookup_valid_i = 0;
    if (n == 1) begin
      ek = (usr && !m_flags[idx][6]) ? 2'd3 : 2'd0;
      ep = b_pa(idx, va);
      m_lru = b_touch(m_lru, idx);
      chk(res_valid_o && res_kind_o == ek, req, {30'd0, res_kind_o}, {30'd0, ek});
      if (ek == 2'd0) chk(res_paddr_o == ep, req, res_paddr_o, ep);
    end else if (n > 1) begin
      chk(res_valid_o && res_kind_o == 2'd2, req, {30'd0, res_kind_o}, 32'd2);
    end else begin
      chk(!res_valid_o && ref_req_o && ref_vaddr_o == va, {req, " R7 req"}, ref_vaddr_o, va);
      @(negedge clk); @(negedge clk);
      chk(ref_req_o && ref_vaddr_o == va, "R7 hold", ref_vaddr_o, va);
      ref_ready_i = 1;
      @(posedge clk); @(negedge clk);
      ref_ready_i = 0;
      chk(!ref_req_o, "R7 drop", 32'(ref_req_o), 32'd0);
      @(negedge clk);
      ref_rsp_valid_i = 1; ref_rsp_kind_i = rk; ref_rsp_vpn_i = va; ref_rsp_asid_i = as;
      ref_rsp_ppn_i = rppn; ref_rsp_flags_i = rfl;
      @(posedge clk); @(negedge clk);
      ref_rsp_valid_i = 0;
      if (rk == 2'd0) begin
        v = b_victim(m_lru);
        m_vpn[v] = va & 32'hFFFF_FC00; m_asid[v] = as; m_ppn[v] = rppn;
        m_flags[v] = rfl & 9'h1DA;
        m_lru = b_touch(m_lru, v);
        ek = (usr && !m_flags[v][6]) ? 2'd3 : 2'd0;
        ep = b_pa(v, va);
      end else begin
        ek = (rk == 2'd2) ? 2'd2 : 2'd1;
        ep = 32'h0;
      end
      chk(res_valid_o && res_kind_o == ek, {req, " R7 R8 refill"}, {30'd0, res_kind_o}, {30'd0, ek});
      if (ek == 2'd0) chk(res_paddr_o == ep, {req, " R7 pa"}, res_paddr_o, ep);
    end
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=<150000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : main
    logic [31:0] v;
    int unused_seed;
    unused_seed = $urandom(32'd4242);
    for (int i = 0; i < 4; i++) begin
      m_vpn[i] = 0; m_ppn[i] = 0; m_asid[i] = 0; m_flags[i] = 0;
    end
    m_lru = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    chk(lookup_ready_o && !res_valid_o && !ref_req_o, "R1 idle",
        {29'd0, lookup_ready_o, res_valid_o, ref_req_o}, 32'h4);
    for (int i = 0; i < 4; i++) begin
      mm_rd(1'b0, i, v);
      chk(v[8] == 1'b0, "R1 invalid", v, 32'h0);
    end

    // R1 R6 R7: fills from reset go to slots 3,2,1,0
    for (int i = 0; i < 4; i++)
      do_lookup(32'h0040_0000 + 32'(i) * 32'h1000 + 32'h123, 1'b0, 8'd5, 2'd0,
                32'h0100_0000 + 32'(i) * 32'h1000, 9'h17D, "R1 fill");
    mm_rd(1'b0, 3, v);
    chk(v == 32'h0040_0105, "R1 R6 first victim", v, 32'h0040_0105);
    mm_rd(1'b0, 0, v);
    chk(v == 32'h0040_3105, "R6 fourth victim", v, 32'h0040_3105);
    mm_rd(1'b1, 3, v);
    chk(v == 32'h0100_0158, "R7 flags masked", v, 32'h0100_0158);

    // R4 hits, R6 order via model
    do_lookup(32'h0040_2ABC, 1'b0, 8'd5, 2'd0, 32'h0, 9'h0, "R4 hit");
    do_lookup(32'h0040_0FFF, 1'b1, 8'd5, 2'd0, 32'h0, 9'h0, "R4 hit user");

    // R2 wrong identifier misses, R8 forwarded faults
    do_lookup(32'h0040_0010, 1'b0, 8'd7, 2'd1, 32'h0, 9'h0, "R2 R8 asid miss");
    do_lookup(32'h0040_0010, 1'b0, 8'd7, 2'd2, 32'h0, 9'h0, "R8 multi rsp");
    for (int i = 0; i < 4; i++) mm_check(i, "R8 unchanged");

    // R2 shared flag, R10 R11 register writes
    mm_wr(1'b0, 2, 32'h0080_0109);
    mm_wr(1'b1, 2, 32'h0200_0142);
    mm_check(2, "R10 R11 rw");
    do_lookup(32'h0080_0155, 1'b0, 8'd5, 2'd1, 32'h0, 9'h0, "R2 shared");

    // R3 page sizes
    mm_wr(1'b0, 1, 32'h0300_0105);
    mm_wr(1'b1, 1, 32'h0550_01D0);
    do_lookup(32'h030A_BCDE, 1'b0, 8'd5, 2'd1, 32'h0, 9'h0, "R3 1M");
    mm_wr(1'b1, 1, 32'h0550_01C0);
    do_lookup(32'h0300_F00D, 1'b0, 8'd5, 2'd1, 32'h0, 9'h0, "R3 64K");
    do_lookup(32'h0301_000D, 1'b0, 8'd5, 2'd1, 32'h0, 9'h0, "R3 64K out");
    mm_wr(1'b1, 1, 32'h0550_0140);
    do_lookup(32'h0300_0377, 1'b0, 8'd5, 2'd1, 32'h0, 9'h0, "R3 1K in");
    do_lookup(32'h0300_0777, 1'b0, 8'd5, 2'd1, 32'h0, 9'h0, "R3 1K out");
    mm_wr(1'b1, 1, 32'h0550_0150);
    do_lookup(32'h0300_0777, 1'b0, 8'd5, 2'd1, 32'h0, 9'h0, "R3 4K");

    // R5 multi-hit
    mm_wr(1'b0, 0, 32'h0300_0105);
    mm_wr(1'b1, 0, 32'h0660_0150);
    do_lookup(32'h0300_0444, 1'b0, 8'd5, 2'd1, 32'h0, 9'h0, "R5 multi");
    do_lookup(32'h0090_0000, 1'b0, 8'd5, 2'd0, 32'h0770_0000, 9'h150, "R5 lru kept");

    // R9 protection
    mm_wr(1'b0, 0, 32'h0500_0105);
    mm_wr(1'b1, 0, 32'h0660_0100);
    do_lookup(32'h0500_0033, 1'b1, 8'd5, 2'd1, 32'h0, 9'h0, "R9 user prot");
    do_lookup(32'h0500_0033, 1'b0, 8'd5, 2'd1, 32'h0, 9'h0, "R9 priv ok");
    do_lookup(32'h00A0_0000, 1'b1, 8'd5, 2'd0, 32'h0123_0000, 9'h110, "R9 refill prot");

    // R11 high PPN forced
    mm_wr(1'b1, 0, 32'h1C00_0540);
    do_lookup(32'h0500_0033, 1'b1, 8'd5, 2'd1, 32'h0, 9'h0, "R11 force");
    mm_rd(1'b1, 0, v);
    chk(v == 32'h1C00_0540, "R11 readback", v, 32'h1C00_0540);

    // random mix
    for (int it = 0; it < 300; it++) begin
      int r;
      int k;
      logic [7:0] as;
      r = int'($urandom % 10);
      k = int'($urandom % 8);
      as = ($urandom % 2) ? 8'd5 : 8'd9;
      if (r < 2) begin
        mm_wr(1'b0, int'($urandom % 4),
              (32'h0040_0000 + (32'(k) << 12) + (($urandom & 3) << 10)) |
              (32'($urandom % 2) << 8) | 32'(as));
      end else if (r == 2) begin
        mm_wr(1'b1, int'($urandom % 4), $urandom);
      end else if (r == 3) begin
        mm_check(int'($urandom % 4), "R10 R11 random");
      end else begin
        int q;
        logic [1:0] rk;
        q = int'($urandom % 8);
        rk = (q < 6) ? 2'd0 : ((q == 6) ? 2'd1 : 2'd2);
        do_lookup(32'h0040_0000 + (32'(k) << 12) + ($urandom & 32'hFFF), 1'($urandom % 2),
                  as, rk, $urandom & 32'h1FFF_FC00, 9'(($urandom & 32'hFF) | 32'h100),
                  "R2 R4 R6 random");
      end
    end
    for (int i = 0; i < 4; i++) mm_check(i, "R10 final");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule